// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. It watches the line on each pulse of a sample tick that runs at sixteen times the bit rate. It confirms a start bit in the middle of the bit, then collects data bits, an optional parity bit and the stop bit, each sampled at the centre of its bit period. A set of framing inputs fixes the character shape: the number of data bits, whether parity is present and which kind, and one or two stop bits. These inputs must be held steady while a character is being received.

Each finished character is presented as a data byte. Three status flags travel with it: parity error, framing error and break. A one-cycle strobe marks each new character. A FIFO sits after this block. When that FIFO reports full at the moment a character finishes, the character is dropped and an overrun pulse is raised in place of the strobe. The serial input passes through a synchronizer before the state machine sees it.

Top module: `rx_deframer`

## Requirements
- R1: After a synchronous reset, all outputs are 0 and the receiver hunts for a start bit.
- R2: A low line seen on a tick while hunting is re-sampled 8 ticks later. If the line is high there, the event is a false start: no character and no status are produced.
- R3: `wlen_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits arrive least significant first, one every 16 ticks after the start confirmation. `data_o` bits above the selected length read 0.
- R4: When `par_en_i` is 1, one parity bit follows the data. `par_mode_i` selects the expected value of that bit: 0 gives odd parity, 1 gives even parity, 2 forces the bit to 1 and 3 forces it to 0. `par_err_o` is 1 when the sampled parity bit differs from the expected value. When `par_en_i` is 0, no parity bit is taken and `par_err_o` is 0.
- R5: `frame_err_o` is 1 when the first stop bit is sampled low.
- R6: With `two_stop_i` = 1, the second stop bit is not checked. The receiver waits 16 more ticks after the first stop sample before it hunts again.
- R7: `break_o` is 1 when every data bit, the parity bit (if enabled) and the first stop bit are low. A break also sets `frame_err_o`. After a break, the receiver waits for the line to go high before it hunts again.
- R8: If `fifo_full_i` is 1 in the cycle a character finishes, `overrun_o` pulses for one cycle, `valid_o` stays 0, and `data_o` and the three status flags keep their previous values.
- R9: `valid_o` pulses for exactly one cycle per accepted character. It is never high in the same cycle as `overrun_o`. `data_o` and the status flags update together with `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Sample tick at 16 times the bit rate, one cycle wide |
| rxd_i | input | 1 | Serial line, idle high |
| wlen_i | input | 2 | Data-length code (5 + code bits) |
| two_stop_i | input | 1 | 1 selects two stop bits |
| par_en_i | input | 1 | Parity bit present |
| par_mode_i | input | 2 | Parity kind: odd, even, forced 1, forced 0 |
| fifo_full_i | input | 1 | Downstream FIFO cannot accept a character |
| data_o | output | 8 | Received character, zero-extended |
| valid_o | output | 1 | New character strobe |
| par_err_o | output | 1 | Parity error for the current character |
| frame_err_o | output | 1 | Framing error for the current character |
| break_o | output | 1 | Break condition for the current character |
| overrun_o | output | 1 | Character dropped because the FIFO was full |

## Verification
The in-RTL assertions check the following on every cycle:
- the strobe is one cycle wide;
- the strobe and the overrun pulse are exclusive;
- an overrun or a strobe matches the previous cycle's FIFO-full state;
- a break always comes with a framing error;
- 5-bit characters carry zero upper bits.

Bit ordering, the parity kinds, false-start rejection, the unchecked second stop bit and the wait for the line to recover after a break can only be shown by the bench's scenarios. The bench compares every output against its tick-counting model on every clock.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_BRK
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ONE  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  // STAGES must be at least 2; reset value is the idle line level.
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_parity.sv
module rx_parity import rx_pkg::*; #(
  parameter int W = CHAR_W
) (
  input  logic [W-1:0] data_i,
  input  par_mode_e    mode_i,
  output logic         exp_o
);
  always_comb begin
    unique case (mode_i)
      PAR_ODD:  exp_o = ~(^data_i);
      PAR_EVEN: exp_o = ^data_i;
      PAR_ONE:  exp_o = 1'b1;
      default:  exp_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer import rx_pkg::*; #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        rxd_i,
  input  logic [1:0]  wlen_i,
  input  logic        two_stop_i,
  input  logic        par_en_i,
  input  logic [1:0]  par_mode_i,
  input  logic        fifo_full_i,
  output logic [7:0]  data_o,
  output logic        valid_o,
  output logic        par_err_o,
  output logic        frame_err_o,
  output logic        break_o,
  output logic        overrun_o
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(CHAR_W);
  localparam int HALF = OSR / 2;

  logic              line_s;
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_bit;
  logic              exp_par;
  logic              mid_start;
  logic              bit_end;
  logic              char_done;
  logic [IW-1:0]     last_idx;
  rx_char_t          done_char;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rxd_i),
    .q_o (line_s)
  );

  rx_parity #(.W(CHAR_W)) u_par (
    .data_i (shreg),
    .mode_i (par_mode_e'(par_mode_i)),
    .exp_o  (exp_par)
  );

  always_comb begin
    mid_start = (cnt == CW'(HALF - 1));
    bit_end   = (cnt == CW'(OSR - 1));
    last_idx  = IW'({1'b0, wlen_i}) + IW'(4);
    char_done = tick_i && (state == ST_STOP) && bit_end;
    done_char.data = shreg;
    done_char.perr = par_en_i && (par_bit != exp_par);
    done_char.ferr = !line_s;
    done_char.brk  = (shreg == '0) && (!par_en_i || !par_bit) && !line_s;
  end

  // receive state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (tick_i) begin
      unique case (state)
        ST_HUNT: if (!line_s) begin
          state <= ST_START;
          cnt   <= '0;
          shreg <= '0;
        end
        ST_START: begin
          if (mid_start) begin
            cnt   <= '0;
            idx   <= '0;
            state <= line_s ? ST_HUNT : ST_DATA;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt        <= '0;
            shreg[idx] <= line_s;
            idx        <= idx + IW'(1);
            if (idx == last_idx) state <= par_en_i ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            cnt     <= '0;
            par_bit <= line_s;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt <= '0;
            if (done_char.brk)   state <= ST_BRK;
            else if (two_stop_i) state <= ST_STOP2;
            else                 state <= ST_HUNT;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_STOP2: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= ST_HUNT;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: if (line_s) state <= ST_HUNT;
      endcase
    end
  end

  // registered character outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      break_o     <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      if (char_done) begin
        if (fifo_full_i) begin
          overrun_o <= 1'b1;
        end else begin
          valid_o     <= 1'b1;
          data_o      <= done_char.data;
          par_err_o   <= done_char.perr;
          frame_err_o <= done_char.ferr;
          break_o     <= done_char.brk;
        end
      end
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && overrun_o));
  assert_ovr_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> $past(fifo_full_i));
  assert_no_valid_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !$past(fifo_full_i));
  assert_break_framing_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && break_o) |-> frame_err_o);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(wlen_i) == 2'd0) |-> (data_o[7:5] == 3'b000));
endmodule

// File: tb/rx_deframer_bench.sv
module rx_deframer_bench;
  localparam int BIT = 64;   // clocks per bit: a tick every 4 clocks, 16 ticks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic rxd_i = 1'b1;
  logic [1:0] wlen_i = 2'd3;
  logic two_stop_i = 1'b0;
  logic par_en_i = 1'b0;
  logic [1:0] par_mode_i = 2'd0;
  logic fifo_full_i = 1'b0;
  logic [7:0] data_o;
  logic valid_o, par_err_o, frame_err_o, break_o, overrun_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int vcnt = 0;
  int ocnt = 0;
  logic [7:0] cap_data = '0;
  logic cap_perr = 1'b0, cap_ferr = 1'b0, cap_brk = 1'b0;

  always #2.5 clk = ~clk;

  rx_deframer u_rx_deframer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rxd_i(rxd_i),
    .wlen_i(wlen_i), .two_stop_i(two_stop_i), .par_en_i(par_en_i),
    .par_mode_i(par_mode_i), .fifo_full_i(fifo_full_i),
    .data_o(data_o), .valid_o(valid_o), .par_err_o(par_err_o),
    .frame_err_o(frame_err_o), .break_o(break_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick generator: one in four clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % 4;
    tick_i <= (tdiv == 0);
  end

  // behavioural reference model
  int h1 = 1, h2 = 1, s;
  int mmode = 0, tk = 0, w = 0;
  int bits[12];
  int e_data = 0, e_perr = 0, e_ferr = 0, e_brk = 0, e_valid = 0, e_ovr = 0;

  task automatic finish_char(input int stopv);
    int n, d, ones, pb, ex, brk;
    n = 5 + int'(wlen_i);
    d = 0; ones = 0;
    for (int i = 0; i < n; i++) begin
      d += bits[i] << i;
      ones += bits[i];
    end
    pb = par_en_i ? bits[n] : 0;
    case (par_mode_i)
      2'd0: ex = (ones % 2 == 0) ? 1 : 0;
      2'd1: ex = ones % 2;
      2'd2: ex = 1;
      default: ex = 0;
    endcase
    brk = (d == 0 && pb == 0 && stopv == 0) ? 1 : 0;
    if (fifo_full_i) e_ovr = 1;
    else begin
      e_valid = 1; e_data = d;
      e_perr = (par_en_i && pb != ex) ? 1 : 0;
      e_ferr = (stopv == 0) ? 1 : 0;
      e_brk = brk;
    end
    if (brk == 1) mmode = 3;
    else if (two_stop_i) begin mmode = 2; w = 0; end
    else mmode = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      h1 = 1; h2 = 1; mmode = 0; tk = 0; w = 0;
      e_data = 0; e_perr = 0; e_ferr = 0; e_brk = 0; e_valid = 0; e_ovr = 0;
    end else begin
      s = h2; h2 = h1; h1 = int'(rxd_i);
      e_valid = 0; e_ovr = 0;
      if (tick_i) begin
        case (mmode)
          0: if (s == 0) begin mmode = 1; tk = 0; end
          1: begin
            tk++;
            if (tk == 8) begin
              if (s == 1) mmode = 0;
            end else if (tk > 8 && (tk - 8) % 16 == 0) begin
              int j, np;
              j = (tk - 8) / 16 - 1;
              np = 5 + int'(wlen_i) + int'(par_en_i);
              if (j < np) bits[j] = s;
              else finish_char(s);
            end
          end
          2: begin w++; if (w == 16) mmode = 0; end
          default: if (s == 1) mmode = 0;
        endcase
      end
    end
  end

  // per-clock comparison and event capture
  always @(negedge clk) begin
    if (!rst) begin
      chk(data_o == e_data[7:0], "R3 data vs model", data_o, e_data);
      chk(par_err_o == e_perr[0], "R4 parity flag vs model", par_err_o, e_perr);
      chk(frame_err_o == e_ferr[0], "R5 framing flag vs model", frame_err_o, e_ferr);
      chk(break_o == e_brk[0], "R7 break flag vs model", break_o, e_brk);
      chk(overrun_o == e_ovr[0], "R8 overrun vs model", overrun_o, e_ovr);
      chk(valid_o == e_valid[0], "R9 strobe vs model", valid_o, e_valid);
      if (valid_o) begin
        vcnt++;
        cap_data = data_o; cap_perr = par_err_o; cap_ferr = frame_err_o; cap_brk = break_o;
      end
      if (overrun_o) ocnt++;
    end
  end

  task automatic drive(input logic v, input int clocks);
    rxd_i <= v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [7:0] d, input int pbit, input logic st1);
    drive(1'b0, BIT);
    for (int i = 0; i < nbits; i++) drive(d[i], BIT);
    if (pbit >= 0) drive(pbit[0], BIT);
    drive(st1, BIT);
    drive(1'b1, 3 * BIT);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  initial begin
    int v0, o0;
    repeat (5) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk({data_o, valid_o, par_err_o, frame_err_o, break_o, overrun_o} == 14'd0,
        "R1 reset outputs", {data_o, valid_o, par_err_o, frame_err_o, break_o, overrun_o}, 0);
    drive(1'b1, 2 * BIT);

    // 8N1
    v0 = vcnt; send(8, 8'hA5, -1, 1'b1);
    chk(vcnt == v0 + 1, "R9 one strobe", vcnt - v0, 1);
    chk(cap_data == 8'hA5, "R3 8-bit lsb first", cap_data, 8'hA5);
    chk(!cap_perr && !cap_ferr && !cap_brk, "R4 clean flags", {cap_perr, cap_ferr, cap_brk}, 0);

    // 5, 6, 7 bit lengths
    wlen_i <= 2'd0; send(5, 8'h15, -1, 1'b1);
    chk(cap_data == 8'h15, "R3 5-bit", cap_data, 8'h15);
    wlen_i <= 2'd1; send(6, 8'h2B, -1, 1'b1);
    chk(cap_data == 8'h2B, "R3 6-bit", cap_data, 8'h2B);
    wlen_i <= 2'd2; send(7, 8'h41, -1, 1'b1);
    chk(cap_data == 8'h41, "R3 7-bit", cap_data, 8'h41);
    wlen_i <= 2'd3;

    // parity kinds
    par_en_i <= 1'b1;
    par_mode_i <= 2'd1; send(8, 8'h3C, 0, 1'b1);
    chk(!cap_perr, "R4 even ok", cap_perr, 0);
    par_mode_i <= 2'd0; send(8, 8'h3C, 0, 1'b1);
    chk(cap_perr, "R4 odd wrong", cap_perr, 1);
    par_mode_i <= 2'd0; send(8, 8'h07, 0, 1'b1);
    chk(!cap_perr && cap_data == 8'h07, "R4 odd ok", cap_perr, 0);
    par_mode_i <= 2'd2; send(8, 8'h81, 0, 1'b1);
    chk(cap_perr, "R4 forced one", cap_perr, 1);
    par_mode_i <= 2'd3; send(8, 8'h81, 0, 1'b1);
    chk(!cap_perr, "R4 forced zero", cap_perr, 0);
    par_en_i <= 1'b0; par_mode_i <= 2'd0;

    // framing error
    send(8, 8'h55, -1, 1'b0);
    chk(cap_ferr && !cap_brk && cap_data == 8'h55, "R5 framing", {cap_ferr, cap_brk}, 2'b10);

    // two stop bits, second one low
    two_stop_i <= 1'b1;
    v0 = vcnt;
    drive(1'b0, BIT);
    for (int i = 0; i < 8; i++) drive(logic'((8'h5A >> i) & 1), BIT);
    drive(1'b1, BIT); drive(1'b0, BIT); drive(1'b1, 3 * BIT);
    chk(vcnt == v0 + 1 && !cap_ferr && cap_data == 8'h5A, "R6 second stop ignored", cap_ferr, 0);
    send(8, 8'hC3, -1, 1'b1);
    chk(cap_data == 8'hC3, "R6 next char after two stops", cap_data, 8'hC3);
    two_stop_i <= 1'b0;

    // break
    v0 = vcnt;
    drive(1'b0, 14 * BIT); drive(1'b1, 3 * BIT);
    chk(vcnt == v0 + 1, "R7 one char per break", vcnt - v0, 1);
    chk(cap_brk && cap_ferr && cap_data == 8'h00, "R7 break flags", {cap_brk, cap_ferr}, 2'b11);
    send(8, 8'h69, -1, 1'b1);
    chk(cap_data == 8'h69 && !cap_brk, "R7 recovery", cap_data, 8'h69);

    // overrun
    v0 = vcnt; o0 = ocnt;
    fifo_full_i <= 1'b1; send(8, 8'h77, -1, 1'b1); fifo_full_i <= 1'b0;
    chk(ocnt == o0 + 1, "R8 overrun pulse", ocnt - o0, 1);
    chk(vcnt == v0 && data_o == 8'h69, "R8 char dropped", data_o, 8'h69);

    // false start
    v0 = vcnt;
    drive(1'b0, 16); drive(1'b1, 3 * BIT);
    chk(vcnt == v0 && data_o == 8'h69, "R2 false start", vcnt - v0, 0);

    summary();
  end
endmodule